// File: doc/BRIEF.md
# Iterative SHA-1 Compression Core

The core computes the SHA-1 hash of a message that the host has already padded and cut into 512-bit blocks. The host sends each block as eight 64-bit beats while `ready` is high. The eighth beat starts 80 compression rounds, one per clock. The core builds the message schedule from a rolling sixteen-word window, so it never stores all eighty schedule words. After round 79 a single extra cycle adds the working words into the 160-bit chaining state.

If the block was marked as the final one, the chaining state is the digest. The core then raises `digestValid`, pulses `finish` and holds the result. It keeps holding it until `enable` opens a new message, which reloads the initial chaining values. If the block was not the final one, `ready` returns high and the next block chains from the updated state.

Top module: `sha1_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the outputs are `ready`=1, `digestValid`=0 and `finish`=0, and `digest` equals the initial chaining value 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0 (A in bits 159:128, E in bits 31:0).
- R2: A single final block produces the standard SHA-1 digest on `digest`. Word A sits in the most significant 32 bits. The empty message gives da39a3ee5e6b4b0d3255bfef95601890afd80709 and "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A non-final block chains into the next one: its working words are added modulo 2^32 to the chaining state. The padded 448-bit test message over two blocks gives 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R4: Beat k (k = 0..7) of a block carries schedule word 2k in `msgData[63:32]` and word 2k+1 in `msgData[31:0]`. `lastBlock` is sampled together with beat 7.
- R5: `ready` falls in the cycle after beat 7 is accepted and stays low for 81 cycles (80 rounds plus one chaining cycle). The block's result appears 81 cycles after the edge that accepts beat 7.
- R6: Beats presented while `ready` is low are ignored and have no effect on the digest.
- R7: `finish` is high for exactly one cycle, namely the first cycle in which `digestValid` is high.
- R8: Once valid, `digest` and `digestValid` hold until `enable` is asserted. The cycle after `enable`, `digestValid` is 0, `ready` is 1 and the chaining state is back at the initial value, so the next message hashes from scratch.
- R9: Asserting `enable` in the middle of loading a block discards the beats already taken. The next eight beats form a fresh first block.
- R10: After a non-final block, `digestValid` stays 0 and `ready` returns to 1, 81 cycles after beat 7 was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start of a new message; reloads the initial chaining value |
| msgValid | input | 1 | A beat is present on `msgData` |
| msgData | input | 64 | Two schedule words per beat, the earlier word in the upper half |
| lastBlock | input | 1 | Marks the current block as final; sampled with beat 7 |
| ready | output | 1 | The core accepts beats |
| digestValid | output | 1 | `digest` holds a finished hash |
| digest | output | 160 | Chaining state: A in the top bits, E in the bottom bits |
| finish | output | 1 | One-cycle pulse when the digest becomes valid |

## Verification
The bench drives beats on the falling edge and samples on the falling edge after each rising edge. Counting from the rising edge that accepts beat 7, `ready` must be low at the first sample. `ready` and `digestValid` must still be low at the sample after 80 further edges. The 81st edge is the due point for the digest, `digestValid` and `finish`, or for `ready` after a non-final block. One sample later `finish` must have dropped while the digest holds. After an `enable` pulse the check falls one edge later, when the initial chaining value and a high `ready` must be visible.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WORD_W         = 32;
  localparam int BLOCK_WORDS    = 16;
  localparam int BUS_W          = 64;
  localparam int ROUNDS         = 80;
  localparam int N_STAGES       = 4;
  localparam int STAGE_LEN      = ROUNDS / N_STAGES;
  localparam int WORDS_PER_BEAT = BUS_W / WORD_W;
  localparam int BEATS          = BLOCK_WORDS / WORDS_PER_BEAT;
  localparam int RND_W          = $clog2(ROUNDS);
  localparam int BEAT_W         = $clog2(BEATS);
  localparam int DIGEST_W       = 5 * WORD_W;

  localparam logic [DIGEST_W-1:0] IV_DIGEST =
    {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};

  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadIv;
    logic       takeBeat;
    logic       startBlock;
    logic       runRound;
    logic [1:0] stage;
    logic       addChain;
  } ctrl_t;

  function automatic word_t rotl(word_t v, int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic word_t ivWord(int i);
    return IV_DIGEST[(4-i)*WORD_W +: WORD_W];
  endfunction

  function automatic word_t roundF(logic [1:0] s, word_t x, word_t y, word_t z);
    case (s)
      2'd0:    return (x & y) | (~x & z);
      2'd2:    return (x & y) | (x & z) | (y & z);
      default: return x ^ y ^ z;
    endcase
  endfunction

  function automatic word_t roundK(logic [1:0] s);
    case (s)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction
endpackage

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
  import sha1_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  logic  msgValid,
  input  logic  lastBlock,
  output logic  ready,
  output logic  digestValid,
  output logic  finish,
  output ctrl_t ctrl
);
  typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_ADD, ST_DONE} state_t;

  state_t            state;
  logic [BEAT_W-1:0] beatCnt;
  logic [RND_W-1:0]  roundCnt;
  logic              lastReg;
  logic              accept;
  logic              finalBeat;

  assign ready     = (state == ST_LOAD);
  assign accept    = msgValid && ready && !enable;
  assign finalBeat = (beatCnt == BEAT_W'(BEATS - 1));

  always_comb begin
    ctrl.loadIv     = enable;
    ctrl.takeBeat   = accept;
    ctrl.startBlock = accept && finalBeat;
    ctrl.runRound   = (state == ST_RUN) && !enable;
    ctrl.addChain   = (state == ST_ADD) && !enable;
    if (roundCnt < RND_W'(STAGE_LEN))          ctrl.stage = 2'd0;
    else if (roundCnt < RND_W'(2 * STAGE_LEN)) ctrl.stage = 2'd1;
    else if (roundCnt < RND_W'(3 * STAGE_LEN)) ctrl.stage = 2'd2;
    else                                       ctrl.stage = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_LOAD;
      beatCnt     <= '0;
      roundCnt    <= '0;
      lastReg     <= 1'b0;
      digestValid <= 1'b0;
      finish      <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (enable) begin
        state       <= ST_LOAD;
        beatCnt     <= '0;
        roundCnt    <= '0;
        digestValid <= 1'b0;
      end else begin
        case (state)
          ST_LOAD: if (accept) begin
            if (finalBeat) begin
              beatCnt  <= '0;
              lastReg  <= lastBlock;
              roundCnt <= '0;
              state    <= ST_RUN;
            end else begin
              beatCnt <= beatCnt + 1'b1;
            end
          end
          ST_RUN: begin
            if (roundCnt == RND_W'(ROUNDS - 1)) begin
              roundCnt <= '0;
              state    <= ST_ADD;
            end else begin
              roundCnt <= roundCnt + 1'b1;
            end
          end
          ST_ADD: begin
            if (lastReg) begin
              state       <= ST_DONE;
              digestValid <= 1'b1;
              finish      <= 1'b1;
            end else begin
              state <= ST_LOAD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sha1_datapath.sv
module sha1_datapath
  import sha1_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  ctrl_t               ctrl,
  input  logic [BUS_W-1:0]    msgData,
  output logic [DIGEST_W-1:0] digest
);
  word_t win [BLOCK_WORDS];
  word_t wk  [5];
  word_t hs  [5];
  word_t nextW;
  word_t tSum;

  // next schedule word, 16 ahead of win[0]
  assign nextW = rotl(win[13] ^ win[8] ^ win[2] ^ win[0], 1);
  assign tSum  = rotl(wk[0], 5) + roundF(ctrl.stage, wk[1], wk[2], wk[3])
               + wk[4] + win[0] + roundK(ctrl.stage);

  always_ff @(posedge clk) begin
    if (ctrl.takeBeat) begin
      for (int i = 0; i < BLOCK_WORDS - WORDS_PER_BEAT; i++)
        win[i] <= win[i + WORDS_PER_BEAT];
      for (int j = 0; j < WORDS_PER_BEAT; j++)
        win[BLOCK_WORDS - WORDS_PER_BEAT + j] <= msgData[BUS_W - 1 - j*WORD_W -: WORD_W];
    end else if (ctrl.runRound) begin
      for (int i = 0; i < BLOCK_WORDS - 1; i++)
        win[i] <= win[i + 1];
      win[BLOCK_WORDS - 1] <= nextW;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.startBlock) begin
      for (int i = 0; i < 5; i++) wk[i] <= hs[i];
    end else if (ctrl.runRound) begin
      wk[0] <= tSum;
      wk[1] <= wk[0];
      wk[2] <= rotl(wk[1], 30);
      wk[3] <= wk[2];
      wk[4] <= wk[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.loadIv) begin
      for (int i = 0; i < 5; i++) hs[i] <= ivWord(i);
    end else if (ctrl.addChain) begin
      for (int i = 0; i < 5; i++) hs[i] <= hs[i] + wk[i];
    end
  end

  for (genvar g = 0; g < 5; g++) begin : g_digest
    assign digest[(4-g)*WORD_W +: WORD_W] = hs[g];
  end
endmodule

// File: rtl/sha1_core.sv
module sha1_core
  import sha1_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                msgValid,
  input  logic [BUS_W-1:0]    msgData,
  input  logic                lastBlock,
  output logic                ready,
  output logic                digestValid,
  output logic [DIGEST_W-1:0] digest,
  output logic                finish
);
  ctrl_t ctrl;

  sha1_ctrl i_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .msgValid(msgValid),
    .lastBlock(lastBlock), .ready(ready), .digestValid(digestValid),
    .finish(finish), .ctrl(ctrl)
  );

  sha1_datapath i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .msgData(msgData), .digest(digest)
  );
endmodule

// File: rtl/sha1_core_chk.sv
module sha1_core_chk
  import sha1_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic                ready,
  input logic                digestValid,
  input logic [DIGEST_W-1:0] digest,
  input logic                finish
);
  logic [RND_W:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst) busyCnt <= '0;
    else if (!ready && !digestValid) busyCnt <= busyCnt + 1'b1;
    else busyCnt <= '0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !digestValid && !finish && digest == IV_DIGEST));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busyCnt <= (RND_W+1)'(ROUNDS + 1));

  // R7
  finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> !finish);

  // R7
  finish_valid_chk: assert property (@(posedge clk) disable iff (rst)
    finish |-> digestValid);

  // R8
  digest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (digestValid && !enable) |=> (digestValid && $stable(digest)));

  // R8
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    enable |=> (!digestValid && ready && digest == IV_DIGEST));
endmodule

bind sha1_core sha1_core_chk i_chk (
  .clk(clk), .rst(rst), .enable(enable), .ready(ready),
  .digestValid(digestValid), .digest(digest), .finish(finish)
);

// File: tb/test_sha1_core.sv
module test_sha1_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enable = 1'b0;
  logic         msgValid = 1'b0;
  logic [63:0]  msgData = '0;
  logic         lastBlock = 1'b0;
  logic         ready;
  logic         digestValid;
  logic [159:0] digest;
  logic         finish;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [159:0] D_ABC = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;

  typedef struct packed {
    logic [511:0] blk;
    logic         last;
    logic         junk;
    logic [159:0] exp;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{blk: {32'h80000000, 480'h0}, last: 1'b1, junk: 1'b0,
      exp: 160'hda39a3ee5e6b4b0d3255bfef95601890afd80709},
    '{blk: {32'h61626380, 448'h0, 32'h00000018}, last: 1'b1, junk: 1'b1,
      exp: D_ABC},
    '{blk: {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
            32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
            32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
            32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000},
      last: 1'b0, junk: 1'b0, exp: 160'h0},
    '{blk: {480'h0, 32'h000001c0}, last: 1'b1, junk: 1'b0,
      exp: 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1}
  };

  sha1_core i_sha1_core (
    .clk(clk), .rst(rst), .enable(enable), .msgValid(msgValid),
    .msgData(msgData), .lastBlock(lastBlock), .ready(ready),
    .digestValid(digestValid), .digest(digest), .finish(finish)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseEnable();
    @(negedge clk); enable = 1'b1;
    @(posedge clk);
    @(negedge clk); enable = 1'b0;
    chk("R8 enable clears valid", {159'h0, digestValid}, 160'h0);
    chk("R8 enable gives ready", {159'h0, ready}, 160'h1);
    chk("R8 enable reloads IV", digest, IV);
  endtask

  // sends a block, then samples at the R5 due points
  task automatic runBlock(input vec_t v, input string req);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      msgValid  = 1'b1;
      msgData   = v.blk[511 - 64*k -: 64];
      lastBlock = (k == 7) ? v.last : 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    msgValid  = v.junk;
    msgData   = 64'hdeadbeef_cafef00d;
    lastBlock = v.junk;
    chk("R5 ready low after beat 7", {159'h0, ready}, 160'h0);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk("R5 still busy at edge 80", {158'h0, ready, digestValid}, 160'h0);
    @(posedge clk);
    @(negedge clk);
    if (v.last) begin
      chk({req, " digest"}, digest, v.exp);
      chk("R7 finish with valid", {158'h0, finish, digestValid}, 160'h3);
      chk("R5 ready low when done", {159'h0, ready}, 160'h0);
      @(negedge clk);
      chk("R7 finish one cycle", {159'h0, finish}, 160'h0);
      chk("R8 digest held", digest, v.exp);
    end else begin
      chk("R10 ready back, not valid", {158'h0, ready, digestValid}, 160'h2);
    end
    msgValid  = 1'b0;
    lastBlock = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {157'h0, ready, digestValid, finish}, 160'h4);
    chk("R1 reset digest", digest, IV);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {157'h0, ready, digestValid, finish}, 160'h4);

    // R2, R3, R4, R6: table walk; messages 0 and 1 use one block, 2..3 chain
    for (int i = 0; i < 4; i++) begin
      if (i == 0 || VECS[i > 0 ? i-1 : 0].last) pulseEnable();
      runBlock(VECS[i], i == 1 ? "R6 R2 R4 abc with junk beats" :
                        i == 0 ? "R2 empty" : "R3 two-block");
    end

    // R8: held over idle cycles
    repeat (5) @(negedge clk);
    chk("R8 digest held idle", digest, VECS[3].exp);
    chk("R8 valid held idle", {159'h0, digestValid}, 160'h1);
    pulseEnable();

    // R9: partial load aborted by enable
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); msgValid = 1'b1; msgData = 64'h0123456789abcdef;
      @(posedge clk);
    end
    @(negedge clk); msgValid = 1'b0;
    pulseEnable();
    runBlock(VECS[1], "R9 abc after abort");

    // R1: reset from a finished state
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset after run", {157'h0, ready, digestValid, finish}, 160'h4);
    chk("R1 reset digest after run", digest, IV);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule